// File: doc/BRIEF.md
# Pin Multiplexer Router

This block connects a group of peripheral function wires to a smaller group of I/O pads. Each pad owns a small select register that software writes through a word-addressed register port. The selected slot of a pad names one function. That function's output level and its output-enable both reach the pad through the same multiplexer. A bus-type function controls the pad direction itself. Any other function drives a fixed direction. Slots with no function attached leave the pad undriven and low.

In the other direction, each function that can take input has a priority multiplexer. It looks at every pad whose current slot names that function and forwards the level of the lowest-numbered such pad. Several pads may therefore select the same function input without conflict. One function output may also drive several pads at once. The slot-to-function table and the per-function attributes are elaboration parameters. Only the select registers are clocked; both routing directions are combinational.

Top module: `pad_router`

## Requirements
- R1: After synchronous reset every pad select register holds 0, so pad k routes its slot 0, and `cfg_rdata` is 0.
- R2: A write with `cfg_addr` below NUM_PADS loads `cfg_wdata` into that pad's select at the rising edge on which `cfg_we` is sampled high. `cfg_rdata` is registered: it shows the select of the pad addressed at the previous rising edge.
- R3: A write with `cfg_addr` at or above NUM_PADS changes no pad's routing. A read of such an address returns 0.
- R4: `pad_out[p]` equals `fn_out[f]`, where f is the FN_IW-bit entry at index p*2^SEL_W+sel[p] of SLOT_MAP, and it follows input changes combinationally. One function may drive several pads. The default table is indexed by slots 0..3: pad0 uses fn0, fn4, fn6, none; pad1 uses fn1, fn5, fn6, fn7; pad2 uses fn2, fn5, fn4, none; pad3 uses fn3, fn7, fn5, fn6.
- R5: `pad_oe[p]` uses the same select and the same f. If bit f of FN_BUS is set, it equals `fn_oe[f]`. Otherwise it equals bit f of FN_OE_CONST. The defaults are FN_BUS=8'h4F and FN_OE_CONST=8'h90.
- R6: A table entry of NUM_FN or more marks an empty slot. A pad that selects an empty slot drives `pad_out`=0 and `pad_oe`=0.
- R7: `fn_in[f]` equals `pad_in[p]` for the lowest p whose selected entry is f, combinationally, when bit f of FN_HAS_IN is set. The default is FN_HAS_IN=8'h6F.
- R8: `fn_in[f]` is 0 when no pad selects f, and it is always 0 when bit f of FN_HAS_IN is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Word address: pad number |
| cfg_wdata | input | SEL_W | Select value to write |
| cfg_rdata | output | SEL_W | Registered select read-back |
| fn_out | input | NUM_FN | Per-function level toward the pads |
| fn_oe | input | NUM_FN | Per-function output-enable (used by bus functions) |
| fn_in | output | NUM_FN | Per-function level from the pads |
| pad_in | input | NUM_PADS | Level sensed at each pad |
| pad_out | output | NUM_PADS | Level driven to each pad |
| pad_oe | output | NUM_PADS | Output-enable for each pad |

## Verification
The bench aims several pads at one input function at the same time and toggles their levels separately. A router that picks the wrong winner, or that ORs the pads together, then shows a wrong `fn_in`. Bus and fixed-direction functions are both exercised with `fn_oe` values that conflict with the fixed setting, which exposes an enable taken from the wrong source. Writes to addresses past the last pad are followed by full routing checks and read-back, which catches an address decode that wraps onto a real pad. Empty slots are selected while every function drives high, so any leakage onto `pad_out` or `pad_oe` is visible.

// File: rtl/pr_pkg.sv
package pr_pkg;
  // Index width for a set of n items (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pr_sel_regs.sv
module pr_sel_regs #(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [SEL_W-1:0]          wdata,
  output logic [SEL_W-1:0]          rdata,
  output logic [NUM_PADS*SEL_W-1:0] sel_flat
);
  localparam int unsigned PAD_IW = pr_pkg::idx_w(NUM_PADS);
  localparam logic [ADDR_W:0] PAD_LIMIT = (ADDR_W+1)'(NUM_PADS);

  logic [SEL_W-1:0] sel_q [NUM_PADS];
  logic             in_range;

  assign in_range = ({1'b0, addr} < PAD_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PADS; i++) sel_q[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && in_range) sel_q[addr[PAD_IW-1:0]] <= wdata;
      rdata <= in_range ? sel_q[addr[PAD_IW-1:0]] : '0;
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_flat
    assign sel_flat[p*SEL_W +: SEL_W] = sel_q[p];

    // R2: a write to this pad lands on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
      (we && ({1'b0, addr} == (ADDR_W+1)'(p))) |=> (sel_q[p] == $past(wdata)));
  end

  // R1: selects are zero right after reset
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_flat == '0));

  // R3: out-of-range writes leave every select untouched
  a_r3_oor_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && !in_range) |=> $stable(sel_flat));
endmodule

// File: rtl/pr_out_mux.sv
module pr_out_mux #(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned NUM_FN = 8,
  parameter int unsigned FN_IW  = 4,
  parameter logic [(2**SEL_W)*FN_IW-1:0] SLOT_ROW = '0,
  parameter logic [NUM_FN-1:0] FN_BUS      = '0,
  parameter logic [NUM_FN-1:0] FN_OE_CONST = '0
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_FN-1:0] fn_out,
  input  logic [NUM_FN-1:0] fn_oe,
  output logic [FN_IW-1:0]  pad_fn,
  output logic              pad_out,
  output logic              pad_oe
);
  localparam int unsigned SLOTS = 2**SEL_W;

  // Slot lookup: which function this pad currently names.
  always_comb begin
    pad_fn = '1;
    for (int s = 0; s < SLOTS; s++)
      if (sel == SEL_W'(s)) pad_fn = SLOT_ROW[s*FN_IW +: FN_IW];
  end

  // Data and enable share one selection; empty slots fall through as 0.
  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    for (int f = 0; f < NUM_FN; f++) begin
      if (pad_fn == FN_IW'(f)) begin
        pad_out = fn_out[f];
        pad_oe  = FN_BUS[f] ? fn_oe[f] : FN_OE_CONST[f];
      end
    end
  end
endmodule

// File: rtl/pr_in_prio.sv
module pr_in_prio #(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned FN_IW    = 4,
  parameter int unsigned FN_ID    = 0,
  parameter bit          HAS_IN   = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PADS*FN_IW-1:0] pad_fn_flat,
  input  logic [NUM_PADS-1:0]       pad_in,
  output logic                      fn_in
);
  logic [NUM_PADS-1:0] match;
  logic [NUM_PADS-1:0] grant;
  logic                found;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_match
    assign match[p] = (pad_fn_flat[p*FN_IW +: FN_IW] == FN_IW'(FN_ID));
  end

  // Lowest-index matching pad wins.
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int p = 0; p < NUM_PADS; p++) begin
      if (match[p] && !found) begin
        grant[p] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign fn_in = HAS_IN ? |(grant & pad_in) : 1'b0;

  // R7: at most one pad forwarded, and only a pad that selects this function
  a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~match) == '0));

  // R8: no pad aimed here means the default level 0
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |-> !fn_in);
endmodule

// File: rtl/pad_router.sv
module pad_router #(
  parameter int unsigned NUM_PADS = 4,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned NUM_FN   = 8,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned FN_IW    = pr_pkg::idx_w(NUM_FN + 1),
  parameter logic [NUM_PADS*(2**SEL_W)*FN_IW-1:0] SLOT_MAP = 64'h6573_8452_7651_8640,
  parameter logic [NUM_FN-1:0] FN_BUS      = 8'h4F,
  parameter logic [NUM_FN-1:0] FN_OE_CONST = 8'h90,
  parameter logic [NUM_FN-1:0] FN_HAS_IN   = 8'h6F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [SEL_W-1:0]    cfg_wdata,
  output logic [SEL_W-1:0]    cfg_rdata,
  input  logic [NUM_FN-1:0]   fn_out,
  input  logic [NUM_FN-1:0]   fn_oe,
  output logic [NUM_FN-1:0]   fn_in,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  localparam int unsigned SLOTS = 2**SEL_W;
  localparam int unsigned ROW_W = SLOTS * FN_IW;

  logic [NUM_PADS*SEL_W-1:0] sel_flat;
  logic [NUM_PADS*FN_IW-1:0] pad_fn_flat;

  pr_sel_regs #(
    .NUM_PADS(NUM_PADS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    pr_out_mux #(
      .SEL_W(SEL_W), .NUM_FN(NUM_FN), .FN_IW(FN_IW),
      .SLOT_ROW(SLOT_MAP[p*ROW_W +: ROW_W]),
      .FN_BUS(FN_BUS), .FN_OE_CONST(FN_OE_CONST)
    ) u_omux (
      .sel(sel_flat[p*SEL_W +: SEL_W]), .fn_out(fn_out), .fn_oe(fn_oe),
      .pad_fn(pad_fn_flat[p*FN_IW +: FN_IW]),
      .pad_out(pad_out[p]), .pad_oe(pad_oe[p])
    );

    // R6: an empty slot never drives the pad
    a_r6_empty_slot: assert property (@(posedge clk) disable iff (rst)
      (pad_fn_flat[p*FN_IW +: FN_IW] >= FN_IW'(NUM_FN)) |-> (!pad_out[p] && !pad_oe[p]));
  end

  for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
    pr_in_prio #(
      .NUM_PADS(NUM_PADS), .FN_IW(FN_IW), .FN_ID(f), .HAS_IN(FN_HAS_IN[f])
    ) u_iprio (
      .clk(clk), .rst(rst), .pad_fn_flat(pad_fn_flat), .pad_in(pad_in),
      .fn_in(fn_in[f])
    );
  end
endmodule

// File: tb/pad_router_tb_top.sv
module pad_router_tb_top;
  localparam int NP = 4;
  localparam int NF = 8;
  localparam logic [63:0] MAP    = 64'h6573_8452_7651_8640;
  localparam logic [7:0]  BUS    = 8'h4F;
  localparam logic [7:0]  OECON  = 8'h90;
  localparam logic [7:0]  HASIN  = 8'h6F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [1:0] cfg_wdata = '0;
  logic [1:0] cfg_rdata;
  logic [NF-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;

  int vectors = 0;
  int errors  = 0;
  int shadow [NP];

  always #10 clk = ~clk;

  pad_router dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fn_out(fn_out),
    .fn_oe(fn_oe), .fn_in(fn_in), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  function automatic int fn_at(int p, int s);
    return int'((MAP >> ((p*4 + s)*4)) & 64'hF);
  endfunction

  function automatic logic exp_out(int p);
    int f = fn_at(p, shadow[p]);
    return (f >= NF) ? 1'b0 : fn_out[f];
  endfunction

  function automatic logic exp_oe(int p);
    int f = fn_at(p, shadow[p]);
    if (f >= NF) return 1'b0;
    return BUS[f] ? fn_oe[f] : OECON[f];
  endfunction

  function automatic int winner(int f);
    for (int p = 0; p < NP; p++) if (fn_at(p, shadow[p]) == f) return p;
    return -1;
  endfunction

  function automatic logic exp_in(int f);
    int w = winner(f);
    if (!HASIN[f] || w < 0) return 1'b0;
    return pad_in[w];
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Full routing check at the ports (R4..R8).
  task automatic check_routes();
    #2;
    for (int p = 0; p < NP; p++) begin
      int f = fn_at(p, shadow[p]);
      if (f >= NF) begin
        chk("R6", $sformatf("pad%0d out", p), int'(pad_out[p]), 0);
        chk("R6", $sformatf("pad%0d oe", p), int'(pad_oe[p]), 0);
      end else begin
        chk("R4", $sformatf("pad%0d out", p), int'(pad_out[p]), int'(exp_out(p)));
        chk("R5", $sformatf("pad%0d oe", p), int'(pad_oe[p]), int'(exp_oe(p)));
      end
    end
    for (int f = 0; f < NF; f++) begin
      if (HASIN[f] && winner(f) >= 0)
        chk("R7", $sformatf("fn%0d in", f), int'(fn_in[f]), int'(exp_in(f)));
      else
        chk("R8", $sformatf("fn%0d in", f), int'(fn_in[f]), 0);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 2'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NP) shadow[a] = d;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 3'(a);
    @(negedge clk);
    if (a < NP) chk("R2", $sformatf("read pad%0d", a), int'(cfg_rdata), shadow[a]);
    else        chk("R3", $sformatf("read addr%0d", a), int'(cfg_rdata), 0);
  endtask

  task automatic drive(logic [NF-1:0] fo, logic [NF-1:0] fe, logic [NP-1:0] pi);
    fn_out = fo; fn_oe = fe; pad_in = pi;
    check_routes();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++) shadow[p] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rdata after reset", int'(cfg_rdata), 0);
    drive('1, '1, 4'b1010);
    drive(8'h0F, 8'h05, 4'b0101);
    for (int p = 0; p < NP; p++) rd(p);

    // R7: three pads on fn5, lowest (pad1) wins
    wr(1, 1); wr(2, 1); wr(3, 2);
    drive('0, '0, 4'b0010);
    chk("R7", "fn5 from pad1 high", int'(fn_in[5]), 1);
    drive('0, '0, 4'b1100);
    chk("R7", "fn5 pad1 low others high", int'(fn_in[5]), 0);

    // R6: empty slot with every function driving high
    wr(0, 3);
    drive('1, '1, '1);
    chk("R6", "pad0 empty out", int'(pad_out[0]), 0);

    // R5: bus fn6 on pads 0,1,3 follows fn_oe; R7 lowest pad0
    wr(0, 2); wr(1, 2); wr(3, 3);
    drive(8'h40, 8'h00, 4'b1010);
    chk("R5", "pad1 oe bus low", int'(pad_oe[1]), 0);
    drive(8'h00, 8'h40, 4'b0001);
    chk("R5", "pad3 oe bus high", int'(pad_oe[3]), 1);
    chk("R7", "fn6 from pad0", int'(fn_in[6]), 1);

    // R5: fixed-direction fn4/fn7 ignore fn_oe
    wr(0, 1); wr(1, 3);
    drive(8'h90, 8'h00, '0);
    chk("R5", "pad1 fn7 oe const", int'(pad_oe[1]), 1);

    // R3: out-of-range writes change nothing
    wr(4, 2); wr(7, 1);
    drive(8'hA5, 8'h5A, 4'b0110);
    rd(5); rd(4);
    for (int p = 0; p < NP; p++) rd(p);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom_range(7, 0));
      int d = int'($urandom_range(3, 0));
      wr(a, d);
      drive(NF'($urandom), NF'($urandom), NP'($urandom));
      if ((i % 8) == 0) rd(int'($urandom_range(7, 0)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule